// File: doc/BRIEF.md
# Cycle-Slip Loss-of-Lock Detector

This block decides whether a clock loop is in lock by watching for phase slips. It samples two clocks, a reference clock and a feedback clock, inside a faster system clock domain and counts the rising edges of each in an up/down phase accumulator. When the reference gets a set number of edges ahead of the feedback clock, or falls that far behind, the block reports a possible cycle slip and re-centres the accumulator. Each slip restarts a retriggerable quiet timer. The loss-of-lock flag drops only when the timer has run a whole window with no further slip. There is no partial lock state.

A 3-bit lock-time code picks the quiet window from eight lengths in binary steps. Code 7 gives the shortest window and each lower code doubles it. The code is captured only when the timer restarts. An acquisition input holds the flag asserted and keeps the timer cleared while the loop is still pulling in, so the flag cannot toggle while the frequency swings around its target. The window length in system clocks is `TICK_DIV * BASE_TICKS * 2^(7-code)`. The default parameters give roughly 0.83 ms up to 106 ms at a 100 MHz system clock.

Top module: `lol_slip_detector`

## Requirements
- R1: While reset is high and on the first cycle after it, `lol_o` is 1 and `slip_o` is 0.
- R2: A rising edge on only the reference clock adds one to the accumulator. A rising edge on only the feedback clock subtracts one. A rising edge on both in the same cycle leaves it unchanged. When the value reaches +SLIP_THRESH or -SLIP_THRESH, one slip is reported and the accumulator returns to zero. With a threshold of 4, three lone reference edges give no slip, the fourth gives one, and eight give two.
- R3: Reference and feedback clocks with the same frequency and phase never produce a slip.
- R4: After the last restart, `lol_o` falls exactly `TICK_DIV * BASE_TICKS * 2^(7-code)` system clock cycles later. Here `code` is the unsigned value of `lock_code_i` captured at that restart, from 0 (longest window) to 7 (shortest window).
- R5: A slip restarts the window. `lol_o` is 1 in the cycle after the slip pulse, and it falls a full window after that restart.
- R6: While `acq_i` is high, `lol_o` is 1 from the next cycle on, whatever the clocks do. The window starts counting only after `acq_i` returns low.
- R7: A change of `lock_code_i` after a restart does not alter the window already being timed.
- R8: Each slip appears on `slip_o` as a pulse exactly one system clock cycle wide.
- R9: Once `lol_o` is 0, it stays 0 until a slip occurs or `acq_i` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both monitored clocks |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| fb_clk_i | input | 1 | Feedback clock, asynchronous to `clk` |
| acq_i | input | 1 | Acquisition active: forces the flag high and clears the timer |
| lock_code_i | input | 3 | Quiet-window select, 0 longest to 7 shortest |
| lol_o | output | 1 | Loss-of-lock flag, 1 = unlocked |
| slip_o | output | 1 | One-cycle pulse on each detected possible cycle slip |

## Verification
The bench builds the block with TICK_DIV=4, BASE_TICKS=2 and SLIP_THRESH=4. With these values every one of the eight windows runs between 8 and 1024 system cycles. The whole code table can therefore be timed to the exact cycle, including the longest window. A threshold of 4 keeps the slip boundary within a few hand-placed clock edges. Both sides of the boundary can then be reached directly: three lone edges with no slip, the fourth with a slip, and re-centring seen as two slips over eight edges.

// File: rtl/lol_pkg.sv
package lol_pkg;

    typedef logic [2:0] lock_code_t;

    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_pair_t;

    // Quiet window in ticks: code 7 is the base length, each lower code doubles it.
    function automatic int unsigned window_ticks(input lock_code_t code,
                                                 input int unsigned base);
        return base << (3'd7 - code);
    endfunction

endpackage

// File: rtl/lol_edge_sync.sv
module lol_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [1:0] sync_q;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], async_i};
            prev_q <= sync_q[1];
        end
    end

    assign rise_o = sync_q[1] & ~prev_q;
endmodule

// File: rtl/lol_phase_acc.sv
module lol_phase_acc
    import lol_pkg::*;
#(
    parameter int SLIP_THRESH = 8,
    parameter int ACC_W       = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  edge_pair_t edges_i,
    output logic       slip_o
);
    localparam logic signed [ACC_W-1:0] THR_P = ACC_W'(SLIP_THRESH);
    localparam logic signed [ACC_W-1:0] THR_N = -THR_P;
    localparam logic signed [ACC_W-1:0] ONE   = ACC_W'(1);

    logic signed [ACC_W-1:0] acc_q, acc_nx;
    logic                    hit;

    always_comb begin
        acc_nx = acc_q;
        if (edges_i.ref_rise && !edges_i.fb_rise)
            acc_nx = acc_q + ONE;
        else if (edges_i.fb_rise && !edges_i.ref_rise)
            acc_nx = acc_q - ONE;
        hit = (acc_nx >= THR_P) || (acc_nx <= THR_N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            slip_o <= 1'b0;
        end else begin
            slip_o <= hit;
            acc_q  <= hit ? '0 : acc_nx;
        end
    end

    AST_ACC_IN_BAND: assert property (@(posedge clk) disable iff (rst)
        (acc_q < THR_P) && (acc_q > THR_N)); // R2

    AST_SLIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        slip_o |=> !slip_o); // R8
endmodule

// File: rtl/lol_quiet_timer.sv
module lol_quiet_timer
    import lol_pkg::*;
#(
    parameter int TICK_DIV   = 1000,
    parameter int BASE_TICKS = 83
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart_i,
    input  lock_code_t code_i,
    output logic       lol_o
);
    localparam int MAX_TICKS = BASE_TICKS * 128;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam int PRE_W     = $clog2(TICK_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q, lim_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            pre_q <= '0;
            cnt_q <= '0;
            lim_q <= CNT_W'(window_ticks(code_i, BASE_TICKS));
            lol_o <= 1'b1;
        end else if (lol_o) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                if (cnt_q == lim_q - CNT_W'(1))
                    lol_o <= 1'b0;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_RESTART_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> lol_o); // R5

    AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (rst)
        (!lol_o && !restart_i) |=> !lol_o); // R9
endmodule

// File: rtl/lol_slip_detector.sv
module lol_slip_detector
    import lol_pkg::*;
#(
    parameter int TICK_DIV    = 1000,
    parameter int BASE_TICKS  = 83,
    parameter int SLIP_THRESH = 8,
    parameter int ACC_W       = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_clk_i,
    input  logic       fb_clk_i,
    input  logic       acq_i,
    input  logic [2:0] lock_code_i,
    output logic       lol_o,
    output logic       slip_o
);
    edge_pair_t edges;
    logic       restart;

    lol_edge_sync u_ref_sync (
        .clk(clk), .rst(rst), .async_i(ref_clk_i), .rise_o(edges.ref_rise)
    );

    lol_edge_sync u_fb_sync (
        .clk(clk), .rst(rst), .async_i(fb_clk_i), .rise_o(edges.fb_rise)
    );

    lol_phase_acc #(.SLIP_THRESH(SLIP_THRESH), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .edges_i(edges), .slip_o(slip_o)
    );

    assign restart = slip_o | acq_i;

    lol_quiet_timer #(.TICK_DIV(TICK_DIV), .BASE_TICKS(BASE_TICKS)) u_timer (
        .clk(clk), .rst(rst), .restart_i(restart),
        .code_i(lock_code_t'(lock_code_i)), .lol_o(lol_o)
    );

    AST_ACQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        acq_i |=> lol_o); // R6

    AST_SLIP_FORCES_LOL: assert property (@(posedge clk) disable iff (rst)
        slip_o |=> lol_o); // R5
endmodule

// File: tb/lol_slip_detector_tb_top.sv
module lol_slip_detector_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV = 4;
    localparam int BASE = 2;
    localparam int THR  = 4;

    // code -> expected lock cycles (TDIV*BASE*2^(7-code))
    localparam int unsigned EXP_CYC [8] = '{1024, 512, 256, 128, 64, 32, 16, 8};

    logic clk = 1'b0;
    logic rst, ref_clk, fb_clk, acq;
    logic [2:0] code;
    logic lol, slip;

    int checks = 0;
    int errors = 0;
    int slip_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lol_slip_detector #(.TICK_DIV(TDIV), .BASE_TICKS(BASE), .SLIP_THRESH(THR), .ACC_W(8)) dut_i (
        .clk(clk), .rst(rst), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk), .acq_i(acq),
        .lock_code_i(code), .lol_o(lol), .slip_o(slip)
    );

    always @(negedge clk) if (slip) slip_seen++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge just after acq dropped (or after start_n edges counted).
    task automatic measure_lock(input int start_n, output int n);
        n = start_n;
        while (n < 5000) begin
            @(posedge clk); #1;
            n++;
            if (!lol) break;
        end
        @(negedge clk);
    endtask

    task automatic drive_clocks(input int pref, input int pfb, input int cycles,
                                input bit want_hi, input bit want_lo, input string tag);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (want_hi && !lol) bad++;
            if (want_lo && lol) bad++;
            ref_clk = (pref > 0) ? ((i % pref) < pref/2) : 1'b0;
            fb_clk  = (pfb  > 0) ? ((i % pfb)  < pfb/2)  : 1'b0;
        end
        @(negedge clk);
        ref_clk = 1'b0;
        fb_clk  = 1'b0;
        if (want_hi || want_lo) check(bad == 0, tag, bad, 0);
    endtask

    task automatic acq_pulse;
        acq = 1'b1;
        step(6);
        acq = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; ref_clk = 1'b0; fb_clk = 1'b0; acq = 1'b0; code = 3'd7;
        step(3);
        check(lol == 1'b1, "R1 lol in reset", lol, 1);
        check(slip == 1'b0, "R1 slip in reset", slip, 0);
        rst = 1'b0;
        step(1);
        check(lol == 1'b1, "R1 lol after reset", lol, 1);

        // R4: table of window codes
        for (int k = 0; k < 8; k++) begin
            code = 3'(k);
            acq_pulse();
            measure_lock(0, n);
            check(n == int'(EXP_CYC[k]), $sformatf("R4 window code %0d", k), n, EXP_CYC[k]);
        end

        // R7: code changed mid-window is ignored
        code = 3'd4;
        acq_pulse();
        @(negedge clk); code = 3'd0;
        measure_lock(1, n);
        check(n == 64, "R7 code change ignored", n, 64);

        // R3 / R9: equal clocks, stays locked, no slip
        slip_seen = 0;
        drive_clocks(8, 8, 300, 1'b0, 1'b1, "R9 lol stays low");
        step(6);
        check(slip_seen == 0, "R3 no slip equal clocks", slip_seen, 0);

        // R2: threshold boundary up and down, recentring
        code = 3'd5;
        slip_seen = 0;
        drive_clocks(4, 0, 12, 1'b0, 1'b0, "");
        step(6);
        check(slip_seen == 0, "R2 three edges no slip", slip_seen, 0);
        check(lol == 1'b0, "R2 still locked below threshold", lol, 0);
        drive_clocks(4, 0, 4, 1'b0, 1'b0, "");
        step(6);
        check(slip_seen == 1, "R2 R8 fourth edge one slip", slip_seen, 1);
        check(lol == 1'b1, "R5 slip sets lol", lol, 1);
        slip_seen = 0;
        drive_clocks(0, 4, 16, 1'b0, 1'b0, "");
        step(6);
        check(slip_seen == 1, "R2 feedback-ahead slip", slip_seen, 1);
        slip_seen = 0;
        drive_clocks(4, 0, 32, 1'b0, 1'b0, "");
        step(6);
        check(slip_seen == 2, "R2 recentre eight edges", slip_seen, 2);

        // R5: slip while locked retriggers full window
        acq_pulse();
        measure_lock(0, n);
        check(n == 32, "R5 lock before slip", n, 32);
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            ref_clk = ((i % 4) < 2);
        end
        n = 0;
        while (n < 50) begin
            @(posedge clk); #1;
            n++;
            if (slip) break;
        end
        check(slip == 1'b1, "R5 slip observed", slip, 1);
        @(posedge clk); #1;
        check(lol == 1'b1, "R5 lol high after slip", lol, 1);
        @(negedge clk); ref_clk = 1'b0;
        measure_lock(1, n);
        check(n == 33, "R5 window restarted by slip", n, 33);

        // R6: acquisition holds flag despite slipping clocks
        acq = 1'b1;
        step(1);
        drive_clocks(6, 10, 400, 1'b1, 1'b0, "R6 lol held during acquisition");
        step(6);
        acq = 1'b0;
        measure_lock(0, n);
        check(n == 32, "R6 window after acquisition", n, 32);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule